// File: doc/BRIEF.md
# Banked cache identification register file

This block is a small, read-mostly register window that tells software how the caches of a processor are arranged. It answers four word addresses inside a larger system control space. Two of the words are constants fixed when the block is built: one lists the cache type present at each level, and the other describes the cache line and type properties. The third word is a window onto an array of cache size descriptors. The fourth word is a selection register that chooses which descriptor the window shows.

The selection register has two separate copies, one for secure accesses and one for non-secure accesses. The security attribute carried by each access picks the copy. Its 4-bit value packs an instruction-not-data flag in bit 0 and the cache level minus one in bits [3:1]. When the level word reports no caches at all, the selection register reads as zero and ignores writes.

Accesses arrive on a plain 32-bit register bus. Read data is registered and appears one cycle after the read strobe. A small two-state response machine tracks this. In ST_IDLE no read was accepted at the last edge. In ST_DATA the read data register was loaded at the last edge. The transitions are: ST_IDLE to ST_DATA on a read strobe (`go_data`), ST_DATA to ST_DATA on a back-to-back read (`stay_data`), ST_DATA to ST_IDLE when no read follows (`go_idle`), and ST_IDLE to ST_IDLE while the bus is quiet (`stay_idle`).

Top module: `cache_id_regfile`

## Requirements
- R1: After reset, both selection copies are 0 and `rd_data` is 0.
- R2: A read at byte offset 0xD78 returns parameter LEVEL_VAL and a read at 0xD7C returns TYPE_VAL. Writes to either offset leave both values unchanged.
- R3: The selection register at 0xD84 holds two copies. `secure`=1 reaches copy 1 and `secure`=0 reaches copy 0. A write through one view never changes the value read through the other.
- R4: A read at 0xD80 returns entry N of SIZE_TABLE, where N is the selection copy of the access's security view. Entry N occupies bits [32N+31:32N] of the table parameter.
- R5: A write to the selection register stores only `wr_data[3:0]`. The selection register always reads back with bits [31:4] as zero.
- R6: When LEVEL_VAL bits [20:0] are all zero, the selection register reads as 0 in both views and ignores writes. In that case the 0xD80 window shows entry 0.
- R7: In the selection index, bit 0 is the instruction-not-data flag and bits [3:1] are the level minus one. A write whose bits [3:1] equal 7 is discarded and the previous value is kept. Any other value is accepted.
- R8: A read at 0xD80 whose index is NUM_SIZE or larger returns 0.
- R9: A read at any other address returns 0, and this includes addresses that are not word aligned. A write to such an address changes no register.
- R10: `rd_data` takes the value addressed by a read strobe on the following clock edge, and it holds that value until the next read strobe. When a read and a write arrive in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W (12) | Byte offset of the access |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 32 | Write data |
| secure | input | 1 | Security attribute of the access, 1 = secure |
| rd_data | output | 32 | Registered read data |

## Verification
The assertions expect `rd_en`, `wr_en`, `addr` and `secure` to be free of X and steady over each clock edge once reset is released. They also expect LEVEL_VAL, TYPE_VAL and SIZE_TABLE to be fixed for the whole run. The bench changes every input only on the falling clock edge and keeps each strobe high for exactly one cycle. It drives defined values on all inputs from time zero. A second instance, built with a level word that has bits only above bit 20, shares the same bus so that the read-as-zero behaviour is exercised by the same stimulus.

// File: rtl/cid_pkg.sv
package cid_pkg;

    localparam int WORD_W  = 32;
    localparam int SEL_W   = 4;
    localparam int CTYPE_W = 21;

    localparam logic [11:0] OFF_LEVEL = 12'hD78;
    localparam logic [11:0] OFF_TYPE  = 12'hD7C;
    localparam logic [11:0] OFF_SIZE  = 12'hD80;
    localparam logic [11:0] OFF_CSEL  = 12'hD84;

    typedef enum logic [2:0] {
        REG_LEVEL,
        REG_TYPE,
        REG_SIZE,
        REG_CSEL,
        REG_NONE
    } reg_sel_e;

    typedef enum logic {
        ST_IDLE,
        ST_DATA
    } rsp_state_e;

    // Caches exist when any per-level type field is nonzero.
    function automatic logic caches_exist(input logic [WORD_W-1:0] lvl);
        return |lvl[CTYPE_W-1:0];
    endfunction

endpackage

// File: rtl/cid_decode.sv
module cid_decode
    import cid_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    localparam logic [ADDR_W-1:0] A_LEVEL = ADDR_W'(OFF_LEVEL);
    localparam logic [ADDR_W-1:0] A_TYPE  = ADDR_W'(OFF_TYPE);
    localparam logic [ADDR_W-1:0] A_SIZE  = ADDR_W'(OFF_SIZE);
    localparam logic [ADDR_W-1:0] A_CSEL  = ADDR_W'(OFF_CSEL);

    initial begin
        if (ADDR_W < 12) $error("cid_decode: ADDR_W must cover offset 0xD84");
    end

    always_comb begin
        if (addr == A_LEVEL)      sel = REG_LEVEL;
        else if (addr == A_TYPE)  sel = REG_TYPE;
        else if (addr == A_SIZE)  sel = REG_SIZE;
        else if (addr == A_CSEL)  sel = REG_CSEL;
        else                      sel = REG_NONE;
    end

endmodule

// File: rtl/cid_sel_bank.sv
module cid_sel_bank
    import cid_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int IDX_W     = SEL_W,
    parameter bit PRESENT   = 1'b1,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] bank_idx,
    input  logic [IDX_W-1:0]  wr_val,
    output logic [IDX_W-1:0]  cur_val
);

    logic [IDX_W-1:0] bank_q [NUM_BANKS];
    logic             level_bad;

    // Level field of all ones is not a legal selection.
    assign level_bad = &wr_val[IDX_W-1:1];

    generate
        if (PRESENT) begin : g_store
            always_ff @(posedge clk) begin
                for (int b = 0; b < NUM_BANKS; b++) begin
                    if (!rst_n) begin
                        bank_q[b] <= '0;
                    end else if (wr_en && (bank_idx == BANK_W'(b)) && !level_bad) begin
                        bank_q[b] <= wr_val;
                    end
                end
            end
        end else begin : g_razwi
            logic unused_razwi;
            assign unused_razwi = ^{clk, rst_n, wr_en, wr_val, level_bad};
            always_comb begin
                for (int b = 0; b < NUM_BANKS; b++) bank_q[b] = '0;
            end
        end
    endgenerate

    assign cur_val = bank_q[bank_idx];

    // A write through one view leaves every other copy untouched.
    generate
        for (genvar g = 0; g < NUM_BANKS; g++) begin : g_iso
            assert_bank_isolated_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && (bank_idx != BANK_W'(g))) |=> $stable(bank_q[g]));
        end
    endgenerate

    // No copy ever holds the reserved level value.
    assert_no_level7_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(&cur_val[IDX_W-1:1]));

endmodule

// File: rtl/cid_size_table.sv
module cid_size_table
    import cid_pkg::*;
#(
    parameter int                          NUM_SIZE = 3,
    parameter int                          IDX_W    = SEL_W,
    parameter logic [NUM_SIZE*WORD_W-1:0] TABLE    = '0
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [WORD_W-1:0] word
);

    localparam int SLOTS = 1 << IDX_W;

    initial begin
        if (NUM_SIZE > SLOTS || NUM_SIZE < 1)
            $error("cid_size_table: NUM_SIZE out of range for the index width");
    end

    logic [WORD_W-1:0] slot [SLOTS];

    generate
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            if (s < NUM_SIZE) begin : g_pop
                assign slot[s] = TABLE[s*WORD_W +: WORD_W];
            end else begin : g_empty
                assign slot[s] = '0;
            end
        end
    endgenerate

    assign word = slot[idx];

endmodule

// File: rtl/cache_id_regfile.sv
module cache_id_regfile
    import cid_pkg::*;
#(
    parameter int                          ADDR_W     = 12,
    parameter logic [WORD_W-1:0]           LEVEL_VAL  = 32'h0900_0023,
    parameter logic [WORD_W-1:0]           TYPE_VAL   = 32'h8303_C003,
    parameter int                          NUM_SIZE   = 3,
    parameter logic [NUM_SIZE*WORD_W-1:0] SIZE_TABLE = {32'h7FFF_E07A, 32'hF007_E01A, 32'hF003_E019}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic              secure,
    output logic [31:0]       rd_data
);

    localparam bit HAS_CACHE = caches_exist(LEVEL_VAL);
    localparam int NUM_BANKS = 2;

    reg_sel_e          sel;
    logic [SEL_W-1:0]  cur_sel;
    logic [WORD_W-1:0] size_word;
    logic [WORD_W-1:0] read_mux;
    rsp_state_e        state_q, state_d;
    logic              unused_wr_hi;

    assign unused_wr_hi = ^wr_data[WORD_W-1:SEL_W];

    cid_decode #(.ADDR_W(ADDR_W)) i_decode (
        .addr (addr),
        .sel  (sel)
    );

    cid_sel_bank #(
        .NUM_BANKS (NUM_BANKS),
        .IDX_W     (SEL_W),
        .PRESENT   (HAS_CACHE)
    ) i_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en && (sel == REG_CSEL)),
        .bank_idx (secure),
        .wr_val   (wr_data[SEL_W-1:0]),
        .cur_val  (cur_sel)
    );

    cid_size_table #(
        .NUM_SIZE (NUM_SIZE),
        .IDX_W    (SEL_W),
        .TABLE    (SIZE_TABLE)
    ) i_table (
        .idx  (cur_sel),
        .word (size_word)
    );

    always_comb begin
        unique case (sel)
            REG_LEVEL: read_mux = LEVEL_VAL;
            REG_TYPE:  read_mux = TYPE_VAL;
            REG_SIZE:  read_mux = size_word;
            REG_CSEL:  read_mux = {{(WORD_W-SEL_W){1'b0}}, cur_sel};
            default:   read_mux = '0;
        endcase
    end

    // Response state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = rd_en ? ST_DATA : ST_IDLE;
            ST_DATA: state_d = rd_en ? ST_DATA : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Output process: read data loads only on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= read_mux;
    end

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    assert_state_tracks_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (state_q == ST_DATA));

    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (sel == REG_NONE)) |=> (rd_data == '0));

    assert_razwi_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!HAS_CACHE && rd_en && (sel == REG_CSEL)) |=> (rd_data == '0));

    assert_oob_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (sel == REG_SIZE) && (int'(cur_sel) >= NUM_SIZE)) |=> (rd_data == '0));

    assert_fixed_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (sel == REG_LEVEL)) |=> (rd_data == LEVEL_VAL));

    assert_select_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (sel == REG_CSEL)) |=> (rd_data[WORD_W-1:SEL_W] == '0));

endmodule

// File: tb/test_cache_id_regfile.sv
`timescale 1ns/1ps
module test_cache_id_regfile;

    localparam logic [31:0] LVL   = 32'h0900_0023;
    localparam logic [31:0] TYP   = 32'h8303_C003;
    localparam logic [31:0] LVL_NC = 32'h0700_0000;
    localparam logic [31:0] E0 = 32'hF003_E019;
    localparam logic [31:0] E1 = 32'hF007_E01A;
    localparam logic [31:0] E2 = 32'h7FFF_E07A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        secure = 1'b0;
    logic [31:0] rd_data, rd_data_nc;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cache_id_regfile #(
        .LEVEL_VAL (LVL), .TYPE_VAL (TYP), .NUM_SIZE (3),
        .SIZE_TABLE ({E2, E1, E0})
    ) i_cache_id_regfile (
        .clk (clk), .rst_n (rst_n), .addr (addr), .rd_en (rd_en), .wr_en (wr_en),
        .wr_data (wr_data), .secure (secure), .rd_data (rd_data)
    );

    cache_id_regfile #(
        .LEVEL_VAL (LVL_NC), .TYPE_VAL (TYP), .NUM_SIZE (3),
        .SIZE_TABLE ({E2, E1, E0})
    ) i_nocache (
        .clk (clk), .rst_n (rst_n), .addr (addr), .rd_en (rd_en), .wr_en (wr_en),
        .wr_data (wr_data), .secure (secure), .rd_data (rd_data_nc)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_read(input logic [11:0] a, input logic sec);
        @(negedge clk);
        addr = a; secure = sec; rd_en = 1'b1; wr_en = 1'b0;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic bus_write(input logic [11:0] a, input logic sec, input logic [31:0] d);
        @(negedge clk);
        addr = a; secure = sec; wr_data = d; wr_en = 1'b1; rd_en = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 rd_data after reset", rd_data, 32'h0);
        bus_read(12'hD84, 1'b1); check("R1 secure select reset", rd_data, 32'h0);
        bus_read(12'hD84, 1'b0); check("R1 nonsecure select reset", rd_data, 32'h0);
    endtask

    task automatic t_fixed_words;
        bus_read(12'hD78, 1'b0); check("R2 level word", rd_data, LVL);
        bus_read(12'hD7C, 1'b1); check("R2 type word", rd_data, TYP);
        bus_write(12'hD78, 1'b0, 32'hFFFF_FFFF);
        bus_write(12'hD7C, 1'b1, 32'h0);
        bus_read(12'hD78, 1'b1); check("R2 level after write", rd_data, LVL);
        bus_read(12'hD7C, 1'b0); check("R2 type after write", rd_data, TYP);
    endtask

    task automatic t_banking;
        bus_write(12'hD84, 1'b1, 32'h2);
        bus_read(12'hD84, 1'b1); check("R3 secure copy written", rd_data, 32'h2);
        bus_read(12'hD84, 1'b0); check("R3 nonsecure copy untouched", rd_data, 32'h0);
        bus_write(12'hD84, 1'b0, 32'h1);
        bus_read(12'hD84, 1'b1); check("R3 secure copy untouched", rd_data, 32'h2);
        bus_read(12'hD84, 1'b0); check("R3 nonsecure copy written", rd_data, 32'h1);
    endtask

    task automatic t_size_window;
        bus_read(12'hD80, 1'b1); check("R4 secure view entry 2", rd_data, E2);
        bus_read(12'hD80, 1'b0); check("R4 nonsecure view entry 1", rd_data, E1);
        bus_write(12'hD84, 1'b0, 32'h0);
        bus_read(12'hD80, 1'b0); check("R4 nonsecure view entry 0", rd_data, E0);
    endtask

    task automatic t_masking;
        bus_write(12'hD84, 1'b0, 32'hFFFF_FFF1);
        bus_read(12'hD84, 1'b0); check("R5 upper bits dropped", rd_data, 32'h1);
        bus_read(12'hD84, 1'b1); check("R5 other view intact", rd_data, 32'h2);
        bus_write(12'hD84, 1'b1, 32'h1234_5680);
        bus_read(12'hD84, 1'b1); check("R5 low nibble zero stored", rd_data, 32'h0);
        bus_write(12'hD84, 1'b1, 32'h2);
    endtask

    task automatic t_level7;
        bus_write(12'hD84, 1'b1, 32'hE);
        bus_read(12'hD84, 1'b1); check("R7 level 7 data rejected", rd_data, 32'h2);
        bus_write(12'hD84, 1'b1, 32'hF);
        bus_read(12'hD84, 1'b1); check("R7 level 7 instr rejected", rd_data, 32'h2);
        bus_write(12'hD84, 1'b1, 32'h3);
        bus_read(12'hD84, 1'b1); check("R7 level 2 instr accepted", rd_data, 32'h3);
    endtask

    task automatic t_oob;
        bus_read(12'hD80, 1'b1); check("R8 index 3 past table", rd_data, 32'h0);
        bus_write(12'hD84, 1'b1, 32'h5);
        bus_read(12'hD80, 1'b1); check("R8 index 5 past table", rd_data, 32'h0);
        bus_write(12'hD84, 1'b1, 32'h2);
        bus_read(12'hD80, 1'b1); check("R8 back in range", rd_data, E2);
    endtask

    task automatic t_unmapped;
        bus_read(12'hD88, 1'b0); check("R9 unmapped 0xD88", rd_data, 32'h0);
        bus_read(12'hD78, 1'b0);
        bus_read(12'h000, 1'b1); check("R9 unmapped 0x000", rd_data, 32'h0);
        bus_read(12'hD78, 1'b0);
        bus_read(12'hD79, 1'b0); check("R9 unaligned offset", rd_data, 32'h0);
        bus_write(12'hD88, 1'b1, 32'h1);
        bus_write(12'hD85, 1'b1, 32'h1);
        bus_read(12'hD84, 1'b1); check("R9 unmapped writes ignored", rd_data, 32'h2);
    endtask

    task automatic t_latency;
        bus_read(12'hD78, 1'b0);
        repeat (3) @(negedge clk);
        check("R10 data held while idle", rd_data, LVL);
        @(negedge clk);
        addr = 12'hD7C; rd_en = 1'b1;
        #1 check("R10 old data before edge", rd_data, LVL);
        @(negedge clk);
        rd_en = 1'b0;
        check("R10 new data after one edge", rd_data, TYP);
        @(negedge clk);
        addr = 12'hD84; secure = 1'b1; rd_en = 1'b1; wr_en = 1'b1; wr_data = 32'h4;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        check("R10 read beside write sees old value", rd_data, 32'h2);
        bus_read(12'hD84, 1'b1); check("R10 write landed", rd_data, 32'h4);
    endtask

    task automatic t_nocache;
        bus_write(12'hD84, 1'b1, 32'h2);
        bus_write(12'hD84, 1'b0, 32'h1);
        bus_read(12'hD84, 1'b1); check("R6 secure select reads zero", rd_data_nc, 32'h0);
        bus_read(12'hD84, 1'b0); check("R6 nonsecure select reads zero", rd_data_nc, 32'h0);
        bus_read(12'hD80, 1'b1); check("R6 window shows entry 0", rd_data_nc, E0);
        bus_read(12'hD78, 1'b0); check("R6 level word upper bits", rd_data_nc, LVL_NC);
        bus_read(12'hD84, 1'b1); check("R6 cached instance still writable", rd_data, 32'h2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fixed_words();
        t_banking();
        t_size_window();
        t_masking();
        t_level7();
        t_oob();
        t_unmapped();
        t_latency();
        t_nocache();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule